// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block produces the active-low reset that holds a microprocessor in reset until its power is good. It then keeps watch on a kick signal that the firmware toggles. Three sources can pull the reset low. The first is a power-good level that some other circuit has already digitised. The second is a watchdog that expects rising edges on the kick input. The third is a manual reset level. An inhibit level suspends the watchdog, for example while a debugger halts the processor.

Every interval is a count of the free-running system clock and is set by a parameter. The parameters are:

- `POR_DLY`, the release delay after power-good or manual reset.
- `WDT_TMO`, the watchdog period.
- `WDT_RST`, the length of the reset pulse that a watchdog timeout produces.

A kick that arrives too early in a period, inside the first `WDT_TMO/10` counts, is not accepted. This keeps a firmware loop that runs too fast from keeping the watchdog satisfied. Each input passes through `SYNC_STAGES` (default 2) flip-flops before the controller uses it. All latencies below assume the default of 2.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, `cpu_rst_n_o` is 0 and the controller is in its power-on hold state. It stays in that state, with `cpu_rst_n_o` at 0, while `pwr_good_i` is 0 after `rst_n` is released.
- R2: Once `pwr_good_i` rises and stays high, `cpu_rst_n_o` rises on the (POR_DLY+2)th rising clock edge after the input change. This is two synchronizer stages plus POR_DLY counted cycles.
- R3: After each release of `cpu_rst_n_o`, if no accepted kick arrives, `cpu_rst_n_o` stays high for exactly WDT_TMO clock cycles and then falls.
- R4: A watchdog timeout holds `cpu_rst_n_o` low for exactly WDT_RST cycles. The output is then released and a fresh watchdog period starts with its count at 0.
- R5: A rising edge of the synchronized `kick_i` is accepted when the period count c is at least WDT_TMO/10 (integer division). The count is 0 in the first high cycle and goes up by one each cycle. An accepted kick restarts the count at 0. A kick seen on the final count c = WDT_TMO-1 wins over the timeout. A raw kick edge driven while the count is j is seen when the count is j+2.
- R6: A kick edge seen while c < WDT_TMO/10 is ignored, and the period keeps counting toward the timeout.
- R7: While the synchronized `inhibit_i` is 1, no watchdog timeout occurs and the count is held at 0. After `inhibit_i` falls, `cpu_rst_n_o` falls on the (WDT_TMO+2)th edge.
- R8: When `man_rst_i` rises, `cpu_rst_n_o` falls on the 3rd rising edge and stays low while `man_rst_i` is 1. After `man_rst_i` falls, `cpu_rst_n_o` rises on the (POR_DLY+3)th edge, which is the full release delay.
- R9: When `pwr_good_i` falls, `cpu_rst_n_o` falls on the 3rd rising edge. Power-good overrides manual reset and the watchdog. A power-good drop during the release delay restarts that delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times every interval |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| pwr_good_i | input | 1 | Digitized supply-good level, 1 = supply in range |
| kick_i | input | 1 | Watchdog kick; rising edges restart the period |
| inhibit_i | input | 1 | 1 = suspend watchdog monitoring |
| man_rst_i | input | 1 | 1 = force processor reset |
| cpu_rst_n_o | output | 1 | Active-low processor reset |

## Verification
The watchdog is driven with a set of single-kick patterns, with the kick placed at different counts within a period:

- No kick, and a kick one count before the end of the ignore window. Both must give the plain timeout length, which shows that early edges have no effect.
- A kick on the first count where it is accepted, and one in mid-period. Both must stretch the high time to the kick point plus a full period, which pins down the ignore-window boundary.
- A kick seen on the very last count, and one that arrives just after the timeout. These separate a kick that beats the timeout from one that comes too late.

Every timeout pulse is measured. Directed sequences then cover three further cases:

- The inhibit hold and the fresh period that follows it.
- Manual reset while power is good and while power is bad.
- A power-good glitch during the release delay, which must restart the delay.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        POR_HOLD  = 2'd0,
        RUN       = 2'd1,
        WDT_RESET = 2'd2,
        MANUAL    = 2'd3
    } sup_state_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [SYNC_STAGES];
    logic [W-1:0] stg_d [SYNC_STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
    import sup_pkg::*;
#(
    parameter int POR_DLY = 370000,
    parameter int WDT_TMO = 310000,
    parameter int WDT_RST = 34000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    input  logic kick_s,
    input  logic inh_s,
    input  logic mr_s,
    output logic cpu_rst_n
);

    localparam int MAX_CNT = (POR_DLY > WDT_TMO) ?
                             ((POR_DLY > WDT_RST) ? POR_DLY : WDT_RST) :
                             ((WDT_TMO > WDT_RST) ? WDT_TMO : WDT_RST);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int IGN_LEN = WDT_TMO / 10;

    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_DLY - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(WDT_TMO - 1);
    localparam logic [CNT_W-1:0] WRST_LAST = CNT_W'(WDT_RST - 1);
    localparam logic [CNT_W-1:0] IGN_CNT   = CNT_W'(IGN_LEN);

    typedef struct packed {
        sup_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             kick_prev;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     kick_edge;
    logic     kick_ok;

    assign kick_edge = kick_s && !st_q.kick_prev;
    assign kick_ok   = kick_edge && (st_q.cnt >= IGN_CNT);

    always_comb begin
        st_d           = st_q;
        st_d.kick_prev = kick_s;
        if (!pg_s) begin
            st_d.state = POR_HOLD;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.state)
                POR_HOLD: begin
                    if (mr_s) begin
                        st_d.state = MANUAL;
                        st_d.cnt   = '0;
                    end else if (st_q.cnt == POR_LAST) begin
                        st_d.state = RUN;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                MANUAL: begin
                    if (!mr_s) begin
                        st_d.state = POR_HOLD;
                        st_d.cnt   = '0;
                    end
                end
                RUN: begin
                    if (mr_s) begin
                        st_d.state = MANUAL;
                        st_d.cnt   = '0;
                    end else if (inh_s || kick_ok) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == TMO_LAST) begin
                        st_d.state = WDT_RESET;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                WDT_RESET: begin
                    if (mr_s) begin
                        st_d.state = MANUAL;
                        st_d.cnt   = '0;
                    end else if (st_q.cnt == WRST_LAST) begin
                        st_d.state = RUN;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.state = POR_HOLD;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state     <= POR_HOLD;
            st_q.cnt       <= '0;
            st_q.kick_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rst_n = (st_q.state == RUN);

    // R9
    pg_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> (st_q.state == POR_HOLD) && !cpu_rst_n);

    // R8
    manual_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_s && mr_s) |=> (st_q.state == MANUAL));

    // R7
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RUN && pg_s && !mr_s && inh_s) |=> (st_q.state == RUN && st_q.cnt == '0));

    // R6
    early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RUN && pg_s && !mr_s && !inh_s && kick_edge && st_q.cnt < IGN_CNT)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R5
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RUN && pg_s && !mr_s && !inh_s && kick_s && !st_q.kick_prev && st_q.cnt >= IGN_CNT)
        |=> (st_q.state == RUN && st_q.cnt == '0));

    // R3
    timeout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == WDT_RESET && $past(st_q.state) == RUN) |-> ($past(st_q.cnt) == TMO_LAST));

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RUN && $past(st_q.state) == WDT_RESET) |-> ($past(st_q.cnt) == WRST_LAST));

    // R2
    release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == RUN && $past(st_q.state) == POR_HOLD) |-> ($past(st_q.cnt) == POR_LAST));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int POR_DLY     = 370000,
    parameter int WDT_TMO     = 310000,
    parameter int WDT_RST     = 34000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic kick_i,
    input  logic inhibit_i,
    input  logic man_rst_i,
    output logic cpu_rst_n_o
);

    localparam int N_IN = 4;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;

    if (WDT_TMO / 10 < 1) begin : g_bad_tmo
        $fatal(1, "WDT_TMO must be at least 10 so the ignore window is non-empty");
    end
    if (POR_DLY < 1 || WDT_RST < 1 || SYNC_STAGES < 1) begin : g_bad_len
        $fatal(1, "interval and stage parameters must be positive");
    end

    assign raw_in = {man_rst_i, inhibit_i, kick_i, pwr_good_i};

    sup_sync #(
        .W           (N_IN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    sup_ctrl #(
        .POR_DLY (POR_DLY),
        .WDT_TMO (WDT_TMO),
        .WDT_RST (WDT_RST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_s      (sync_in[0]),
        .kick_s    (sync_in[1]),
        .inh_s     (sync_in[2]),
        .mr_s      (sync_in[3]),
        .cpu_rst_n (cpu_rst_n_o)
    );

endmodule

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;

    localparam int POR = 20;
    localparam int TMO = 30;
    localparam int WRS = 5;
    localparam int NV  = 6;

    // kick drive point j (count at drive time, -1 = none) and expected high cycles (TMO=30, window 3)
    localparam int KICK_AT [NV] = '{-1, 0, 1, 10, 27, 28};
    localparam int EXP_HI  [NV] = '{30, 30, 34, 43, 60, 30};

    logic clk = 1'b0;
    logic rst_n;
    logic pg, kick, inh, mr;
    logic rst_o;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    wdt_supervisor #(
        .POR_DLY (POR),
        .WDT_TMO (TMO),
        .WDT_RST (WRS)
    ) i_wdt_supervisor (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good_i  (pg),
        .kick_i      (kick),
        .inhibit_i   (inh),
        .man_rst_i   (mr),
        .cpu_rst_n_o (rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges_until(input logic level, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_o != level && n < 400);
    endtask

    task automatic run_period(input int j, output int hi);
        int idx = 0;
        hi = 1;
        if (j == 0) kick = 1'b1;
        while (hi < 400) begin
            @(negedge clk);
            idx++;
            if (idx == j) kick = 1'b1;
            if (idx == j + 2) kick = 1'b0;
            if (!rst_o) break;
            hi++;
        end
        kick = 1'b0;
    endtask

    task automatic measure_low(output int lo);
        lo = 1;
        while (lo < 400) begin
            @(negedge clk);
            if (rst_o) break;
            lo++;
        end
    endtask

    task automatic hold_check(input string req, input logic level, input int cyc);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rst_o != level) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int hi;
        int lo;
        rst_n = 1'b0; pg = 1'b0; kick = 1'b0; inh = 1'b0; mr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset low", int'(rst_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 hold with pg low", int'(rst_o), 0);

        // R2 power-up release
        pg = 1'b1;
        edges_until(1'b1, n);
        chk("R2 release delay", n, POR + 2);

        // R3 R5 R6 kick placement table, R4 pulse length
        for (int v = 0; v < NV; v++) begin
            run_period(KICK_AT[v], hi);
            chk($sformatf("R3/R5/R6 high time kick_at=%0d", KICK_AT[v]), hi, EXP_HI[v]);
            measure_low(lo);
            chk("R4 timeout pulse", lo, WRS);
        end

        // R7 inhibit
        inh = 1'b1;
        hold_check("R7 no timeout while inhibited", 1'b1, 100);
        inh = 1'b0;
        edges_until(1'b0, n);
        chk("R7 fresh period after inhibit", n, TMO + 2);
        measure_low(lo);
        chk("R4 pulse after inhibit", lo, WRS);

        // R8 manual reset while running
        mr = 1'b1;
        edges_until(1'b0, n);
        chk("R8 manual assert latency", n, 3);
        hold_check("R8 held low", 1'b0, 40);
        mr = 1'b0;
        edges_until(1'b1, n);
        chk("R8 release after manual", n, POR + 3);

        // R9 power-good fall and priority
        pg = 1'b0;
        edges_until(1'b0, n);
        chk("R9 pg fall latency", n, 3);
        mr = 1'b1;
        repeat (5) @(negedge clk);
        pg = 1'b1;
        hold_check("R9/R8 manual holds after pg rise", 1'b0, 40);
        mr = 1'b0;
        edges_until(1'b1, n);
        chk("R8 release after manual with pg", n, POR + 3);

        // R9 glitch during release delay restarts it
        pg = 1'b0;
        edges_until(1'b0, n);
        chk("R9 pg fall latency 2", n, 3);
        pg = 1'b1;
        repeat (10) @(negedge clk);
        pg = 1'b0;
        repeat (3) @(negedge clk);
        pg = 1'b1;
        edges_until(1'b1, n);
        chk("R9 delay restarts after glitch", n, POR + 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule